// File: doc/BRIEF.md
# Processor Debug Trigger Endpoint

This block sits on the processor side of a cross-trigger connection. It turns the core's own debug events into outgoing triggers, and it turns incoming trigger requests into commands for the core. Going out, it raises a cross-halt trigger while the core is committed to entering the halted state. It also raises a counter-overflow trigger when the performance-counter overflow status vector leaves the all-zero state. That trigger is either a single-cycle pulse or a level that is held until software clears the status.

Coming in, the block filters debug (halt) requests and restart requests against the current core state and the invasive-debug enable. It then issues halt and restart commands to the core. It also reports two registered status flags: one shows that the core is halted, and the other shows that it has restarted since it last halted. A controller reads these to confirm that a restart took effect before it sends the next one.

All outputs are registered. Each output reflects the inputs sampled at the previous rising clock edge.

Top module: `dbg_trig_endpoint`

## Requirements
- R1: While `rst_n` is low, every output is 0.
- R2: `xhalt_trig` is 1 in the cycle after a cycle with `entry_commit`=1, `in_halt`=0 and `noninv_en`=1. It is 0 in the cycle after `in_halt` is seen as 1, and it never rises without a committed entry in the preceding cycle.
- R3: With `noninv_en`=0, `xhalt_trig` stays 0 even during a committed entry.
- R4: With `ovf_multi`=1, `ovf_trig` goes to 1 one cycle after `ovf_status` changes from all-zero to nonzero. It stays 1 while `ovf_status` remains nonzero and returns to 0 one cycle after `ovf_status` is all-zero again.
- R5: With `ovf_multi`=0, `ovf_trig` is a one-cycle pulse on the zero-to-nonzero change. It does not fire again until `ovf_status` has been all-zero.
- R6: Overflow triggering does not depend on `inv_en` or `noninv_en`.
- R7: `halt_cmd` is 1 in the cycle after a cycle with `dbg_req`=1, `inv_en`=1 and `in_halt`=0. A debug request seen while `in_halt`=1 gives no command.
- R8: `restart_cmd` is 1 in the cycle after a cycle with `restart_req`=1, `inv_en`=1 and `in_halt`=1. A restart request seen while `in_halt`=0 gives no command.
- R9: With `inv_en`=0, neither `halt_cmd` nor `restart_cmd` is produced.
- R10: `halted` equals `in_halt` delayed by one cycle. `restarted` is set one cycle after `in_halt` falls and cleared one cycle after it rises.
- R11: The overflow trigger depends only on whether the vector was all-zero in the previous cycle and is nonzero now. When a clear and a new overflow in the same cycle turn one nonzero value into another nonzero value, no trigger is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| inv_en | input | 1 | Invasive debug enabled |
| noninv_en | input | 1 | Non-invasive debug enabled |
| entry_commit | input | 1 | Core is committed to entering the halted state |
| in_halt | input | 1 | Core is in the halted state |
| dbg_req | input | 1 | Incoming debug (halt) request trigger |
| restart_req | input | 1 | Incoming restart request trigger |
| ovf_multi | input | 1 | 1: held overflow trigger, 0: pulse |
| ovf_status | input | NUM_CNT | Performance-counter overflow status vector |
| xhalt_trig | output | 1 | Cross-halt trigger |
| ovf_trig | output | 1 | Counter-overflow trigger |
| halt_cmd | output | 1 | Halt command to the core |
| restart_cmd | output | 1 | Restart command to the core |
| halted | output | 1 | Status: core halted |
| restarted | output | 1 | Status: core restarted since last halt |

## Verification
Every result passes through exactly one register, so each output is due in the cycle after the stimulus that causes it. The overflow trigger is the exception to the simple rule only in that it also compares against the status sampled one cycle earlier. The bench applies each table row on a falling edge and checks all six outputs at the next falling edge, which is one rising edge later. The vector sequence is ordered so that state carried between rows, such as the previous overflow status and the halted/restarted history, is part of every expected value.

// File: rtl/dbg_trig_pkg.sv
package dbg_trig_pkg;

    typedef struct packed {
        logic prev_nz;
        logic trig;
    } ovf_state_t;

    typedef struct packed {
        logic xhalt;
        logic halt_cmd;
        logic restart_cmd;
        logic halted;
        logic restarted;
    } ctl_state_t;

endpackage

// File: rtl/dbg_ovf_trig.sv
module dbg_ovf_trig
    import dbg_trig_pkg::*;
#(
    parameter int NUM_CNT = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ovf_multi,
    input  logic [NUM_CNT-1:0] ovf_status,
    output logic               ovf_trig
);

    ovf_state_t st_d, st_q;
    logic       any_set;
    logic       first_set;

    always_comb begin
        any_set    = |ovf_status;
        first_set  = any_set && !st_q.prev_nz;
        st_d       = st_q;
        st_d.prev_nz = any_set;
        if (ovf_multi) begin
            st_d.trig = first_set || (st_q.trig && any_set);
        end else begin
            st_d.trig = first_set;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ovf_trig = st_q.trig;

    p_ovf_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_trig && !ovf_multi) |=> !ovf_trig);

    p_ovf_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_trig && ovf_multi && (|ovf_status)) |=> ovf_trig);

    p_ovf_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_status == '0) |=> !ovf_trig);

endmodule

// File: rtl/dbg_halt_ctrl.sv
module dbg_halt_ctrl
    import dbg_trig_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic inv_en,
    input  logic noninv_en,
    input  logic entry_commit,
    input  logic in_halt,
    input  logic dbg_req,
    input  logic restart_req,
    output logic xhalt_trig,
    output logic halt_cmd,
    output logic restart_cmd,
    output logic halted,
    output logic restarted
);

    ctl_state_t st_d, st_q;

    always_comb begin
        st_d             = st_q;
        st_d.xhalt       = noninv_en && entry_commit && !in_halt;
        st_d.halt_cmd    = inv_en && dbg_req && !in_halt;
        st_d.restart_cmd = inv_en && restart_req && in_halt;
        st_d.halted      = in_halt;
        if (st_q.halted && !in_halt) begin
            st_d.restarted = 1'b1;
        end else if (!st_q.halted && in_halt) begin
            st_d.restarted = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign xhalt_trig  = st_q.xhalt;
    assign halt_cmd    = st_q.halt_cmd;
    assign restart_cmd = st_q.restart_cmd;
    assign halted      = st_q.halted;
    assign restarted   = st_q.restarted;

    p_xhalt_commit_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(xhalt_trig) |-> $past(entry_commit));

    p_xhalt_noninv_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !noninv_en |=> !xhalt_trig);

    p_halt_cmd_r7: assert property (@(posedge clk) disable iff (!rst_n)
        halt_cmd |-> !halted);

    p_restart_cmd_r8: assert property (@(posedge clk) disable iff (!rst_n)
        restart_cmd |-> halted);

    p_inv_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !inv_en |=> (!halt_cmd && !restart_cmd));

    p_restarted_r10: assert property (@(posedge clk) disable iff (!rst_n)
        halted |-> !restarted);

endmodule

// File: rtl/dbg_trig_endpoint.sv
module dbg_trig_endpoint #(
    parameter int NUM_CNT = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               inv_en,
    input  logic               noninv_en,
    input  logic               entry_commit,
    input  logic               in_halt,
    input  logic               dbg_req,
    input  logic               restart_req,
    input  logic               ovf_multi,
    input  logic [NUM_CNT-1:0] ovf_status,
    output logic               xhalt_trig,
    output logic               ovf_trig,
    output logic               halt_cmd,
    output logic               restart_cmd,
    output logic               halted,
    output logic               restarted
);

    dbg_halt_ctrl u_ctl (
        .clk          (clk),
        .rst_n        (rst_n),
        .inv_en       (inv_en),
        .noninv_en    (noninv_en),
        .entry_commit (entry_commit),
        .in_halt      (in_halt),
        .dbg_req      (dbg_req),
        .restart_req  (restart_req),
        .xhalt_trig   (xhalt_trig),
        .halt_cmd     (halt_cmd),
        .restart_cmd  (restart_cmd),
        .halted       (halted),
        .restarted    (restarted)
    );

    dbg_ovf_trig #(
        .NUM_CNT (NUM_CNT)
    ) u_ovf (
        .clk        (clk),
        .rst_n      (rst_n),
        .ovf_multi  (ovf_multi),
        .ovf_status (ovf_status),
        .ovf_trig   (ovf_trig)
    );

    // R6: overflow path is independent of the debug enables
    p_ovf_indep_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(ovf_status) == '0 && (|ovf_status)) |=> ovf_trig);

endmodule

// File: tb/dbg_trig_endpoint_tb.sv
`timescale 1ns/1ps
module dbg_trig_endpoint_tb;

    localparam int NUM_CNT = 32;
    localparam int NROWS   = 20;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic inv_en = 1'b0, noninv_en = 1'b0, entry_commit = 1'b0, in_halt = 1'b0;
    logic dbg_req = 1'b0, restart_req = 1'b0, ovf_multi = 1'b0;
    logic [NUM_CNT-1:0] ovf_status = '0;
    logic xhalt_trig, ovf_trig, halt_cmd, restart_cmd, halted, restarted;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    dbg_trig_endpoint #(.NUM_CNT(NUM_CNT)) u_dut (
        .clk(clk), .rst_n(rst_n), .inv_en(inv_en), .noninv_en(noninv_en),
        .entry_commit(entry_commit), .in_halt(in_halt), .dbg_req(dbg_req),
        .restart_req(restart_req), .ovf_multi(ovf_multi), .ovf_status(ovf_status),
        .xhalt_trig(xhalt_trig), .ovf_trig(ovf_trig), .halt_cmd(halt_cmd),
        .restart_cmd(restart_cmd), .halted(halted), .restarted(restarted)
    );

    // Row: {req#(4), inv, noninv, commit, halt, dbg, rst, multi, status(8), expected(6)}
    // expected bits: xhalt ovf halt_cmd restart_cmd halted restarted
    localparam logic [24:0] VEC [NROWS] = '{
        {4'd1,  7'b1100000, 8'h00, 6'b000000}, // R1 idle
        {4'd2,  7'b1110000, 8'h00, 6'b100000}, // R2 committed entry
        {4'd2,  7'b1101000, 8'h00, 6'b000010}, // R2 drop once halted, R10
        {4'd7,  7'b1101100, 8'h00, 6'b000010}, // R7 request while halted ignored
        {4'd8,  7'b1101010, 8'h00, 6'b000110}, // R8 restart while halted
        {4'd10, 7'b1100000, 8'h00, 6'b000001}, // R10 restarted set
        {4'd8,  7'b1100010, 8'h00, 6'b000001}, // R8 restart while running ignored
        {4'd7,  7'b1100100, 8'h00, 6'b001001}, // R7 halt command
        {4'd9,  7'b0110100, 8'h00, 6'b100001}, // R9 debug request ignored
        {4'd9,  7'b0101010, 8'h00, 6'b000010}, // R9 restart ignored, R10 cleared
        {4'd3,  7'b1010000, 8'h00, 6'b000001}, // R3 no cross-halt
        {4'd4,  7'b1000001, 8'h01, 6'b010001}, // R4 rise
        {4'd4,  7'b1000001, 8'h03, 6'b010001}, // R4 held
        {4'd4,  7'b1000001, 8'h00, 6'b000001}, // R4 cleared
        {4'd5,  7'b1000000, 8'h04, 6'b010001}, // R5 pulse
        {4'd11, 7'b1000000, 8'h02, 6'b000001}, // R11 nonzero to nonzero
        {4'd5,  7'b0000000, 8'h00, 6'b000001}, // R5 back to zero
        {4'd6,  7'b0000000, 8'h08, 6'b010001}, // R6 enables off
        {4'd6,  7'b0000001, 8'h08, 6'b010001}, // R6 held in multicycle
        {4'd4,  7'b1000001, 8'h00, 6'b000001}  // R4 cleared
    };

    function automatic logic [5:0] outs();
        return {xhalt_trig, ovf_trig, halt_cmd, restart_cmd, halted, restarted};
    endfunction

    task automatic check(input int req, input logic [5:0] exp);
        checks++;
        if (outs() !== exp) begin
            errors++;
            $display("FAIL R%0d: outputs %b expected %b", req, outs(), exp);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(1, 6'b000000); // R1 reset state
        rst_n = 1'b1;
        for (int i = 0; i < NROWS; i++) begin
            {inv_en, noninv_en, entry_commit, in_halt, dbg_req, restart_req, ovf_multi}
                = VEC[i][20:14];
            ovf_status = {{(NUM_CNT-8){1'b0}}, VEC[i][13:6]};
            @(negedge clk);
            check(int'(VEC[i][24:21]), VEC[i][5:0]);
        end
        // Directed: high bit of the vector alone triggers (R4)
        ovf_multi = 1'b1; ovf_status = '0;
        @(negedge clk);
        ovf_status = {1'b1, {(NUM_CNT-1){1'b0}}};
        @(negedge clk);
        check(4, 6'b010001);
        // Directed: reset in the middle of activity (R1)
        in_halt = 1'b1; entry_commit = 1'b1; noninv_en = 1'b1;
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check(1, 6'b000000);
        rst_n = 1'b1;
        done = 1'b1;
    end

    initial begin
        int cyc = 0;
        while (!done && cyc < 5000) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run did not complete, actual hung expected done");
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule